// File: doc/BRIEF.md
# Synchronous Binary Counter with Load and Clear

A parameterised synchronous up-counter (four bits by default) whose every change is gated by a single enable input. While enabled, the counter does one of three things on each rising clock edge. It either counts up by one, returns to zero, or takes a parallel data word. While disabled it keeps its value, whatever the load and clear inputs request.

Each bit is built as a toggle cell. A bit flips on an enabled count step only when every less significant bit is already 1. The carry output is the enable ANDed with the all-ones condition of the count. It can drive the enable of a further stage, so that several instances form a wider counter, or it can signal an event once per full cycle of the counter.

Top module: `sync_counter`

## Requirements
- R1: While `rst` is high at a rising edge, `count` becomes 0 on that edge. Reset is synchronous and active high.
- R2: While `en` is low, `count` keeps its value across the edge for every combination of `ld` and `clr`.
- R3: With `en`=1, `ld`=0 and `clr`=0, `count` increases by one on the next rising edge.
- R4: When the count is all ones (15 at the default width) and the counter is enabled to count up, it wraps to 0.
- R5: With `en`=1 and `clr`=1, `count` becomes 0 on the next rising edge.
- R6: With `en`=1, `ld`=1 and `clr`=0, `count` takes the value of `din` on the next rising edge.
- R7: When `ld` and `clr` are both 1 while enabled, clear wins and the count becomes 0.
- R8: `carry` is combinational. It is 1 exactly when `en`=1 and every bit of `count` is 1, and it is 0 otherwise.
- R9: On an up-count step, bit n flips only when all lower bits are 1, so a count of 0011 becomes 0100.
- R10: If one stage's `carry` drives the `en` of a second stage, and that second stage has `ld`=`clr`=0, the two stages count as one counter twice as wide. The low stage holds the less significant half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Enable; gates every change of the count |
| ld | input | 1 | Parallel load request |
| clr | input | 1 | Synchronous clear request, higher priority than load |
| din | input | WIDTH | Parallel load data |
| count | output | WIDTH | Current count |
| carry | output | 1 | Enable AND all count bits set |

## Verification
A wrong toggle condition inside a single cell shows up as a wrong `count` on the very next enabled edge. A broken link in the all-ones chain, however, stays hidden until the count reaches a value whose lower bits are all 1. For that reason the bench runs through full wraps and includes the 0011 step. A fault in the carry shows on the port within the same cycle, but only at the all-ones count. The cascaded second stage lets such a fault be seen a second time, as a high half that advances on the wrong edge.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_STEP = 2'd1,
        OP_ZERO = 2'd2,
        OP_TAKE = 2'd3
    } ctr_op_e;

    // Enable gates everything; clear outranks load.
    function automatic ctr_op_e pick_op(input logic en, input logic ld, input logic clr);
        if (!en)
            return OP_HOLD;
        else if (clr)
            return OP_ZERO;
        else if (ld)
            return OP_TAKE;
        else
            return OP_STEP;
    endfunction

    typedef struct packed {
        ctr_op_e op;
        logic    rst;
    } ctr_ctl_t;

endpackage

// File: rtl/ctr_ctrl.sv
module ctr_ctrl
    import ctr_pkg::*;
(
    input  logic     rst,
    input  logic     en,
    input  logic     ld,
    input  logic     clr,
    output ctr_ctl_t ctl
);
    always_comb begin
        ctl.rst = rst;
        ctl.op  = pick_op(en, ld, clr);
    end
endmodule

// File: rtl/ctr_cell.sv
module ctr_cell
    import ctr_pkg::*;
(
    input  logic     clk,
    input  ctr_ctl_t ctl,
    input  logic     lower_set,
    input  logic     d,
    output logic     q
);
    logic q_nxt;

    always_comb begin
        unique case (ctl.op)
            OP_ZERO: q_nxt = 1'b0;
            OP_TAKE: q_nxt = d;
            OP_STEP: q_nxt = q ^ lower_set;
            default: q_nxt = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (ctl.rst)
            q <= 1'b0;
        else
            q <= q_nxt;
    end
endmodule

// File: rtl/sync_counter.sv
module sync_counter
    import ctr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             ld,
    input  logic             clr,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] count,
    output logic             carry
);
    localparam int CHAIN = WIDTH + 1;

    ctr_ctl_t         ctl;
    logic [CHAIN-1:0] ones_below;

    ctr_ctrl u_ctrl (
        .rst (rst),
        .en  (en),
        .ld  (ld),
        .clr (clr),
        .ctl (ctl)
    );

    assign ones_below[0] = 1'b1;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign ones_below[b+1] = ones_below[b] & count[b];

        ctr_cell u_cell (
            .clk       (clk),
            .ctl       (ctl),
            .lower_set (ones_below[b]),
            .d         (din[b]),
            .q         (count[b])
        );
    end

    assign carry = en & ones_below[WIDTH];
endmodule

// File: rtl/sync_counter_chk.sv
module sync_counter_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             ld,
    input logic             clr,
    input logic [WIDTH-1:0] din,
    input logic [WIDTH-1:0] count,
    input logic             carry
);
    localparam logic [WIDTH-1:0] ALL1 = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};

    p_reset_zero_r1: assert property (@(posedge clk) rst |=> count == '0);
    p_hold_off_r2: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(count));
    p_step_up_r3: assert property (@(posedge clk) disable iff (rst)
        (en && !ld && !clr) |=> count == $past(count) + ONE);
    p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (en && !ld && !clr && count == ALL1) |=> count == '0);
    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (en && clr) |=> count == '0);
    p_load_r6: assert property (@(posedge clk) disable iff (rst)
        (en && ld && !clr) |=> count == $past(din));
    p_clr_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (en && ld && clr) |=> count == '0);
    p_carry_needs_en_r8: assert property (@(posedge clk) disable iff (rst)
        carry |-> (en && count == ALL1));
    p_carry_full_r8: assert property (@(posedge clk) disable iff (rst)
        (en && count == ALL1) |-> carry);
endmodule

bind sync_counter sync_counter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .ld    (ld),
    .clr   (clr),
    .din   (din),
    .count (count),
    .carry (carry)
);

// File: tb/test_sync_counter.sv
`timescale 1ns/1ps
module test_sync_counter;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en  = 1'b0;
    logic         ld  = 1'b0;
    logic         clr = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] count, count_hi;
    logic         carry, carry_hi;

    int errors = 0;
    int checks = 0;
    int m_lo = 0;
    int m_hi = 0;

    always #2.5 clk = ~clk;

    sync_counter #(.WIDTH(W)) i_sync_counter (
        .clk(clk), .rst(rst), .en(en), .ld(ld), .clr(clr), .din(din),
        .count(count), .carry(carry)
    );

    // R10: second stage enabled by the first stage's carry
    sync_counter #(.WIDTH(W)) i_hi (
        .clk(clk), .rst(rst), .en(carry), .ld(1'b0), .clr(1'b0), .din('0),
        .count(count_hi), .carry(carry_hi)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Apply one cycle of inputs; compare before the edge, update model after it.
    task automatic step(input string req, input logic e, input logic l,
                        input logic c, input int d);
        int exp_carry;
        en = e; ld = l; clr = c; din = W'(d);
        #1;
        exp_carry = (e && m_lo == 15) ? 1 : 0;
        chk({req, " count"}, int'(count), m_lo);
        chk("R8 carry", int'(carry), exp_carry);
        chk("R10 high stage", int'(count_hi), m_hi);
        @(posedge clk);
        if (exp_carry == 1) m_hi = (m_hi + 1) % 16;
        if (e) begin
            if (c) m_lo = 0;
            else if (l) m_lo = d;
            else m_lo = (m_lo + 1) % 16;
        end
        #1;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        chk("R1 reset", int'(count), 0);
        chk("R1 reset hi", int'(count_hi), 0);

        // R3 plain counting
        for (int i = 0; i < 3; i++) step("R3", 1, 0, 0, 0);
        // R9: 0011 -> 0100
        chk("R9 at 3", int'(count), 3);
        step("R9", 1, 0, 0, 0);
        chk("R9 low bits flipped", int'(count), 4);

        // R2 hold for every ld/clr combination
        step("R2", 0, 0, 0, 9);
        step("R2", 0, 1, 0, 9);
        step("R2", 0, 0, 1, 9);
        step("R2", 0, 1, 1, 9);
        chk("R2 held", int'(count), 4);

        // R6 load
        step("R6", 1, 1, 0, 13);
        chk("R6 loaded", int'(count), 13);
        // R4 wrap via 15, R8 carry seen at 15
        step("R4", 1, 0, 0, 0);
        step("R4", 1, 0, 0, 0);
        step("R4", 1, 0, 0, 0);
        chk("R4 wrapped", int'(count), 0);

        // R8: at 15 with enable low, carry must be 0
        step("R6", 1, 1, 0, 15);
        step("R8", 0, 0, 0, 0);
        step("R8", 1, 0, 0, 0);

        // R5 clear
        step("R6", 1, 1, 0, 10);
        step("R5", 1, 0, 1, 0);
        chk("R5 cleared", int'(count), 0);

        // R7 clear beats load
        step("R6", 1, 1, 0, 7);
        step("R7", 1, 1, 1, 12);
        chk("R7 clear wins", int'(count), 0);

        // R10 long cascaded run
        for (int i = 0; i < 300; i++) step("R10", 1, 0, 0, 0);
        step("R1", 1, 0, 0, 0);

        // R1 reset mid-count
        rst = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        m_lo = 0; m_hi = 0;
        chk("R1 reset again", int'(count), 0);
        chk("R1 reset again hi", int'(count_hi), 0);
        step("R3", 1, 0, 0, 0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule